// File: doc/BRIEF.md
# South Bridge Interrupt Routing Matrix

This block collects the level-sensitive interrupt requests inside a multi-function south bridge and merges them onto sixteen ISA IRQ lines. There are two kinds of source. Four external PCI interrupt pins each take a 4-bit route field packed into function-0 configuration bytes. The on-chip functions 1 to 7 each take a full 8-bit interrupt-line byte. Each IRQ line is high whenever at least one asserted source currently has a legal route to that IRQ number. The two IDE channel interrupts skip the routing table and drive IRQ 14 and IRQ 15 directly.

A route of zero or all-ones switches a source off. A route of 2 is never legal. A route above the source's ceiling is also illegal. The ceiling is 14 for functions 2, 3 and 5 and 15 for every other source. A source with an illegal route drives nothing, and while it is asserted it sets a sticky error flag. Outputs are derived combinationally from the raw source levels and the current route registers. A rewritten route therefore leaves no stale IRQ behind once the write edge has passed.

The error flag is held by a two-state machine. `ERR_IDLE` moves to `ERR_HELD` on any clock edge at which an asserted source has an illegal route. `ERR_HELD` returns to `ERR_IDLE` on an edge that carries a clear write while no asserted source is illegal. Otherwise it stays where it is.

Top module: `irq_route_matrix`

## Requirements
- R1: After reset every route holds 0, `isa_irq` is all low even with every source asserted, and `route_err` is 0.
- R2: With function code 0, the route of pin A is bits [7:4] of the byte at address 0x55. Pin B uses bits [3:0] of 0x56, pin C bits [7:4] of 0x56, and pin D bits [7:4] of 0x57. An asserted pin with route n in 1..15 (n not 2) drives `isa_irq[n]`.
- R3: The route of function f (1..7) is the byte written with function code f at address 0x3C. An asserted function with a legal route n drives `isa_irq[n]`.
- R4: A route of 0x00 or 0xFF disables its source: it drives no IRQ and never sets `route_err`.
- R5: A route of 2 is illegal for every source. Such a source drives no IRQ, and while it is asserted, `route_err` is 1 after the next clock edge.
- R6: For functions 2, 3 and 5 a route of 15 is illegal. For every other source 15 is legal.
- R7: A route byte from 16 to 0xFE is illegal for every function. It drives nothing and flags as in R5.
- R8: Each `isa_irq[n]` is the OR of all asserted sources legally routed to n. It stays high until the last of them drops.
- R9: Once the write edge that changes a route has passed, the source drives only its new IRQ, and the old one is released.
- R10: `ide_chan_irq[0]` drives `isa_irq[14]` and `ide_chan_irq[1]` drives `isa_irq[15]`, whatever the routes hold.
- R11: `route_err` is sticky. A write with function code 0 at address 0x5F with bit 0 set clears it, unless an illegal asserted source is present at the same edge, in which case it stays 1. The same write with bit 0 clear has no effect.
- R12: `isa_irq[0]` is never driven.
- R13: Writes to any other address, or any other function/address pairing, change no route. Bits [3:0] of 0x55 and 0x57 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_func | input | 3 | Function number of the write |
| cfg_addr | input | 8 | Byte address of the write |
| cfg_wdata | input | 8 | Write data byte |
| fn_irq_lvl | input | 7 | Levels of on-chip functions 1..7 (bit f = function f) |
| pci_pin_lvl | input | 4 | Levels of external pins A..D (bit 0 = A) |
| ide_chan_irq | input | 2 | IDE channel interrupts, hardwired to IRQ 14/15 |
| isa_irq | output | 16 | ISA IRQ levels |
| route_err | output | 1 | Sticky invalid-route flag |

## Verification
Source levels reach `isa_irq` in the same cycle. A route write is seen on `isa_irq` only once its write edge has passed. `route_err` changes one edge after the condition that sets or clears it. The bench drives every input just after a falling edge and samples one time unit later. Combinational results are read in that same half-cycle, and write and flag results are read after the next falling edge, so each check falls one settled half-cycle away from the rising edge it depends on. Every source is swept through its full set of route values, from disabled through legal to illegal, and the expected IRQ vector and flag are computed arithmetically from the route value and the source's ceiling.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int NUM_IRQ   = 16;
    localparam int NUM_FN    = 8;
    localparam int NUM_PIN   = 4;
    localparam int NUM_SRC   = NUM_FN + NUM_PIN;
    localparam int FN_W      = $clog2(NUM_FN);
    localparam int ROUTE_W   = 8;
    localparam int PIN_RT_W  = 4;

    localparam int IRQ_FORBIDDEN = 2;
    localparam int IDE_IRQ_BASE  = 14;
    localparam int IDE_CHANS     = 2;

    localparam logic [7:0] LINE_ADDR    = 8'h3C;
    localparam logic [7:0] ERR_CLR_ADDR = 8'h5F;
    localparam logic [7:0] ROUTE_OFF_LO = 8'h00;
    localparam logic [7:0] ROUTE_OFF_HI = 8'hFF;

    typedef enum logic {
        ERR_IDLE,
        ERR_HELD
    } err_state_e;

    // Highest legal IRQ for a source; sources at or above NUM_FN are pins.
    function automatic int src_ceiling(input int src);
        if (src == 2 || src == 3 || src == 5)
            return 14;
        return NUM_IRQ - 1;
    endfunction

    // Function-0 byte address that holds the route nibble of a pin.
    function automatic logic [7:0] pin_byte(input int pin);
        case (pin)
            0:       return 8'h55;
            1:       return 8'h56;
            2:       return 8'h56;
            default: return 8'h57;
        endcase
    endfunction

    // 1 when the pin's nibble is the upper half of its byte.
    function automatic logic pin_upper(input int pin);
        return (pin != 1);
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int N_FN    = NUM_FN,
    parameter int N_PIN   = NUM_PIN,
    parameter int N_SRC   = N_FN + N_PIN,
    parameter int F_W     = $clog2(N_FN),
    parameter int RT_W    = ROUTE_W,
    parameter int PRT_W   = PIN_RT_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [F_W-1:0]              cfg_func,
    input  logic [7:0]                  cfg_addr,
    input  logic [RT_W-1:0]             cfg_wdata,
    output logic [N_SRC-1:0][RT_W-1:0]  src_route,
    output logic                        err_clr
);

    localparam int PAD_W = RT_W - PRT_W;

    logic [N_FN-1:0][RT_W-1:0]   line_q;
    logic [N_PIN-1:0][PRT_W-1:0] pin_q;
    logic                        fn0_sel;

    assign fn0_sel = cfg_we && (cfg_func == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            pin_q  <= '0;
        end else if (cfg_we) begin
            for (int f = 1; f < N_FN; f++) begin
                if (cfg_func == F_W'(f) && cfg_addr == LINE_ADDR)
                    line_q[f] <= cfg_wdata;
            end
            if (cfg_func == '0) begin
                for (int p = 0; p < N_PIN; p++) begin
                    if (cfg_addr == pin_byte(p)) begin
                        if (pin_upper(p))
                            pin_q[p] <= cfg_wdata[RT_W-1 -: PRT_W];
                        else
                            pin_q[p] <= cfg_wdata[PRT_W-1:0];
                    end
                end
            end
        end
    end

    assign err_clr = fn0_sel && (cfg_addr == ERR_CLR_ADDR) && cfg_wdata[0];

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        if (s < N_FN) begin : g_fn
            assign src_route[s] = line_q[s];
        end else begin : g_pin
            assign src_route[s] = {{PAD_W{1'b0}}, pin_q[s-N_FN]};
        end
    end

endmodule

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int N_FN  = NUM_FN,
    parameter int N_SRC = NUM_SRC,
    parameter int N_IRQ = NUM_IRQ,
    parameter int RT_W  = ROUTE_W
) (
    input  logic [N_SRC-1:0][RT_W-1:0]  src_route,
    input  logic [N_SRC-1:0]            src_lvl,
    output logic [N_SRC-1:0][N_IRQ-1:0] src_hit,
    output logic [N_SRC-1:0]            src_bad
);

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        localparam int CEIL = (s < N_FN) ? src_ceiling(s) : (N_IRQ - 1);

        logic off;
        logic bad;
        logic good;

        assign off  = (src_route[s] == ROUTE_OFF_LO) || (src_route[s] == ROUTE_OFF_HI);
        assign bad  = !off && ((src_route[s] == RT_W'(IRQ_FORBIDDEN))
                               || (src_route[s] > RT_W'(CEIL)));
        assign good = !off && !bad;

        always_comb begin
            for (int j = 0; j < N_IRQ; j++)
                src_hit[s][j] = good && src_lvl[s] && (src_route[s] == RT_W'(j));
        end

        assign src_bad[s] = bad && src_lvl[s];
    end

endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge
    import irq_route_pkg::*;
#(
    parameter int N_SRC  = NUM_SRC,
    parameter int N_IRQ  = NUM_IRQ,
    parameter int N_IDE  = IDE_CHANS,
    parameter int IDE_LO = IDE_IRQ_BASE
) (
    input  logic [N_SRC-1:0][N_IRQ-1:0] src_hit,
    input  logic [N_IDE-1:0]            ide_chan_irq,
    output logic [N_IRQ-1:0]            isa_irq
);

    logic [N_IRQ-1:0] routed;

    always_comb begin
        routed = '0;
        for (int s = 0; s < N_SRC; s++)
            routed = routed | src_hit[s];
    end

    for (genvar j = 0; j < N_IRQ; j++) begin : g_irq
        if (j >= IDE_LO && j < IDE_LO + N_IDE) begin : g_ide
            assign isa_irq[j] = routed[j] | ide_chan_irq[j-IDE_LO];
        end else begin : g_plain
            assign isa_irq[j] = routed[j];
        end
    end

endmodule

// File: rtl/irq_route_errflag.sv
module irq_route_errflag
    import irq_route_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic illegal_any,
    input  logic err_clr,
    output logic route_err
);

    err_state_e state_q;
    err_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ERR_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_IDLE: if (illegal_any)             state_d = ERR_HELD;
            ERR_HELD: if (err_clr && !illegal_any) state_d = ERR_IDLE;
            default:                               state_d = ERR_IDLE;
        endcase
    end

    always_comb begin
        route_err = (state_q == ERR_HELD);
    end

endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
    import irq_route_pkg::*;
#(
    parameter int N_FN  = NUM_FN,
    parameter int N_PIN = NUM_PIN,
    parameter int N_IRQ = NUM_IRQ,
    parameter int N_IDE = IDE_CHANS,
    parameter int F_W   = $clog2(N_FN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [F_W-1:0]    cfg_func,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [N_FN-1:1]   fn_irq_lvl,
    input  logic [N_PIN-1:0]  pci_pin_lvl,
    input  logic [N_IDE-1:0]  ide_chan_irq,
    output logic [N_IRQ-1:0]  isa_irq,
    output logic              route_err
);

    localparam int N_SRC = N_FN + N_PIN;

    logic [N_SRC-1:0][ROUTE_W-1:0] src_route;
    logic [N_SRC-1:0][N_IRQ-1:0]   src_hit;
    logic [N_SRC-1:0]              src_bad;
    logic [N_SRC-1:0]              src_lvl;
    logic                          err_clr;
    logic                          illegal_any;

    // Function 0 is not itself a source; its slot stays low.
    assign src_lvl     = {pci_pin_lvl, fn_irq_lvl, 1'b0};
    assign illegal_any = |src_bad;

    irq_route_regs #(
        .N_FN (N_FN),
        .N_PIN(N_PIN),
        .N_SRC(N_SRC),
        .F_W  (F_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_func (cfg_func),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .src_route(src_route),
        .err_clr  (err_clr)
    );

    irq_route_decode #(
        .N_FN (N_FN),
        .N_SRC(N_SRC),
        .N_IRQ(N_IRQ)
    ) decode_i (
        .src_route(src_route),
        .src_lvl  (src_lvl),
        .src_hit  (src_hit),
        .src_bad  (src_bad)
    );

    irq_route_merge #(
        .N_SRC(N_SRC),
        .N_IRQ(N_IRQ),
        .N_IDE(N_IDE)
    ) merge_i (
        .src_hit     (src_hit),
        .ide_chan_irq(ide_chan_irq),
        .isa_irq     (isa_irq)
    );

    irq_route_errflag errflag_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .illegal_any(illegal_any),
        .err_clr    (err_clr),
        .route_err  (route_err)
    );

endmodule

// File: rtl/irq_route_matrix_chk.sv
module irq_route_matrix_chk
    import irq_route_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [FN_W-1:0]    cfg_func,
    input logic [7:0]         cfg_addr,
    input logic [7:0]         cfg_wdata,
    input logic [IDE_CHANS-1:0] ide_chan_irq,
    input logic [NUM_IRQ-1:0] isa_irq,
    input logic               route_err,
    input logic               illegal_any
);

    logic clear_wr;
    assign clear_wr = cfg_we && (cfg_func == '0) && (cfg_addr == ERR_CLR_ADDR) && cfg_wdata[0];

    p_irq0_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !isa_irq[0]);

    p_ide_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ide_chan_irq[0] |-> isa_irq[IDE_IRQ_BASE]);

    p_ide_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ide_chan_irq[1] |-> isa_irq[IDE_IRQ_BASE+1]);

    p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_any |=> route_err);

    p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (route_err && !clear_wr) |=> route_err);

    p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(route_err) |-> $past(illegal_any));

    p_err_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (route_err && clear_wr && !illegal_any) |=> !route_err);

endmodule

bind irq_route_matrix irq_route_matrix_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_func    (cfg_func),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .ide_chan_irq(ide_chan_irq),
    .isa_irq     (isa_irq),
    .route_err   (route_err),
    .illegal_any (illegal_any)
);

// File: tb/irq_route_matrix_tb.sv
module irq_route_matrix_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_func;
    logic [7:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [7:1]  fn_irq_lvl;
    logic [3:0]  pci_pin_lvl;
    logic [1:0]  ide_chan_irq;
    logic [15:0] isa_irq;
    logic        route_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_route_matrix dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_func    (cfg_func),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .fn_irq_lvl  (fn_irq_lvl),
        .pci_pin_lvl (pci_pin_lvl),
        .ide_chan_irq(ide_chan_irq),
        .isa_irq     (isa_irq),
        .route_err   (route_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wr(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_func = f; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    // Sources 1..7 are functions, 8..11 are pins A..D.
    task automatic set_route(input int s, input logic [7:0] v);
        if (s < 8) wr(3'(s), 8'h3C, v);
        else case (s - 8)
            0: wr(3'd0, 8'h55, {v[3:0], 4'h0});
            1: wr(3'd0, 8'h56, {4'h0, v[3:0]});
            2: wr(3'd0, 8'h56, {v[3:0], 4'h0});
            default: wr(3'd0, 8'h57, {v[3:0], 4'h0});
        endcase
    endtask

    task automatic set_lvl(input int s, input logic b);
        if (s < 8) fn_irq_lvl[s] = b;
        else pci_pin_lvl[s-8] = b;
    endtask

    function automatic int ceil_of(input int s);
        return (s == 2 || s == 3 || s == 5) ? 14 : 15;
    endfunction

    function automatic logic is_off(input logic [7:0] v);
        return (v == 8'h00 || v == 8'hFF);
    endfunction

    function automatic logic is_bad(input int s, input logic [7:0] v);
        return !is_off(v) && (v == 8'd2 || int'(v) > ceil_of(s));
    endfunction

    function automatic logic [15:0] exp_vec(input int s, input logic [7:0] v);
        if (is_off(v) || is_bad(s, v)) return 16'h0;
        return 16'h1 << v;
    endfunction

    function automatic string tag_of(input int s, input logic [7:0] v);
        if (is_off(v)) return "R4";
        if (v == 8'd2) return "R5";
        if (v == 8'd15 && ceil_of(s) == 14) return "R6";
        if (int'(v) > 15) return "R7";
        return (s >= 8) ? "R2" : "R3";
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_func = '0; cfg_addr = '0; cfg_wdata = '0;
        fn_irq_lvl = '0; pci_pin_lvl = '0; ide_chan_irq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state with every source asserted
        @(negedge clk);
        fn_irq_lvl = '1; pci_pin_lvl = '1; #1;
        chk("R1 irq", isa_irq, 16'h0);
        @(negedge clk); #1;
        chk("R1 flag", route_err, 1'b0);
        fn_irq_lvl = '0; pci_pin_lvl = '0;

        // R2..R7, R12: sweep every source through its route values
        for (int s = 1; s < 12; s++) begin
            for (int k = 0; k < ((s < 8) ? 21 : 16); k++) begin
                logic [7:0] v;
                v = (k < 18) ? 8'(k) : (k == 18) ? 8'h80 : (k == 19) ? 8'hFE : 8'hFF;
                if (s >= 8) v = 8'(k);
                set_route(s, v);
                @(negedge clk);
                set_lvl(s, 1'b1); #1;
                chk(tag_of(s, v), isa_irq, exp_vec(s, v));
                chk("R12", isa_irq[0], 1'b0);
                @(negedge clk); #1;
                chk({tag_of(s, v), " flag"}, route_err, is_bad(s, v));
                set_lvl(s, 1'b0);
                @(negedge clk); #1;
                chk("R11 sticky", route_err, is_bad(s, v));
                wr(3'd0, 8'h5F, 8'h01);
                chk("R11 clear", route_err, 1'b0);
            end
            set_route(s, 8'h00);
        end

        // R8: OR of several sources on one IRQ
        set_route(1, 8'd5); set_route(4, 8'd5); set_route(8, 8'd5);
        @(negedge clk);
        fn_irq_lvl[1] = 1'b1; fn_irq_lvl[4] = 1'b1; #1;
        chk("R8 both", isa_irq, 16'h0020);
        fn_irq_lvl[1] = 1'b0; #1;
        chk("R8 one left", isa_irq, 16'h0020);
        fn_irq_lvl[4] = 1'b0; pci_pin_lvl[0] = 1'b1; #1;
        chk("R8 pin", isa_irq, 16'h0020);
        pci_pin_lvl[0] = 1'b0; #1;
        chk("R8 none", isa_irq, 16'h0000);

        // R9: route change releases the old IRQ
        set_route(6, 8'd7);
        fn_irq_lvl[6] = 1'b1; #1;
        chk("R9 first", isa_irq, 16'h0080);
        set_route(6, 8'd9);
        chk("R9 moved", isa_irq, 16'h0200);
        set_route(6, 8'h00);
        chk("R9 off", isa_irq, 16'h0000);
        fn_irq_lvl[6] = 1'b0;

        // R10: IDE channels hardwired
        @(negedge clk);
        ide_chan_irq = 2'b01; #1;
        chk("R10 ch0", isa_irq, 16'h4000);
        ide_chan_irq = 2'b10; #1;
        chk("R10 ch1", isa_irq, 16'h8000);
        ide_chan_irq = 2'b11; #1;
        chk("R10 both", isa_irq, 16'hC000);
        ide_chan_irq = 2'b00;

        // R11: clear semantics
        set_route(1, 8'd2);
        @(negedge clk);
        fn_irq_lvl[1] = 1'b1;
        @(negedge clk); #1;
        chk("R11 set", route_err, 1'b1);
        fn_irq_lvl[1] = 1'b0;
        wr(3'd0, 8'h5F, 8'h00);
        chk("R11 bit0 low", route_err, 1'b1);
        fn_irq_lvl[1] = 1'b1;
        wr(3'd0, 8'h5F, 8'h01);
        chk("R11 set wins", route_err, 1'b1);
        fn_irq_lvl[1] = 1'b0;
        wr(3'd0, 8'h5F, 8'h01);
        chk("R11 cleared", route_err, 1'b0);

        // R13: writes that must not touch any route
        set_route(1, 8'h00);
        set_route(8, 8'h00);
        fn_irq_lvl[1] = 1'b1; pci_pin_lvl[0] = 1'b1;
        wr(3'd1, 8'h3D, 8'd5);
        chk("R13 addr", isa_irq, 16'h0000);
        wr(3'd0, 8'h55, 8'h07);
        chk("R13 low nibble", isa_irq, 16'h0000);
        wr(3'd1, 8'h55, 8'h50);
        chk("R13 wrong func", isa_irq, 16'h0000);
        wr(3'd0, 8'h3C, 8'd6);
        chk("R13 func0 line", isa_irq, 16'h0000);
        wr(3'd0, 8'h57, 8'h0B);
        pci_pin_lvl = 4'b1000; #1;
        chk("R13 pin D low nibble", isa_irq, 16'h0000);
        @(negedge clk); #1;
        chk("R13 flag", route_err, 1'b0);

        fn_irq_lvl = '0; pci_pin_lvl = '0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule